// File: doc/BRIEF.md
# Read-Armed Write Port Controller

This block gives a bus slot that carries only read cycles a 16-bit latched output port and an 8-bit input port. The slot has no direction line, so a write cannot be told apart from any other strobe on its own. Instead, software first reads a dedicated "arm" word. That read sets an internal arm flag. The next lower-strobe access to the write word then copies the whole data bus into the output register. A read of the input word places the eight input pins on the low byte of the data bus for as long as the access lasts.

Address lines A15..A1 arrive on `addr_i`, with bit 0 carrying A1. An access is decoded only when A15..A3 are all high. A2 and A1 then pick one of four word slots:

| A2 | A1 | Slot |
|----|----|------|
| 1 | 1 | arm read |
| 1 | 0 | port write |
| 0 | 1 | input read |
| 0 | 0 | spare |

Both strobes are active low. Each one passes through a two-stage synchronizer. Actions fire once, on the synchronized asserting (falling) edge. Address and data must stay stable while a strobe is asserted.

A small state machine holds the arm flag. It has two states, `ST_DISARMED` and `ST_ARMED`, and three transitions:
- **arm**: DISARMED to ARMED, or ARMED to ARMED, on a decoded arm read.
- **consume**: ARMED to DISARMED on a port write, in the default mode.
- **disarm**: ARMED to DISARMED on a lower-strobe access to the spare slot, in block mode.

The parameter `BLOCK_MODE` selects block mode. In block mode a port write leaves the flag set, so one arm read can be followed by several writes.

Top module: `armed_out_port`

## Requirements
- R1: After reset, `pins_out_o` is 0, `data_oe_o` is 0, and the arm flag is clear.
- R2: No action of any kind occurs unless every one of A15..A3 (`addr_i[14:2]`) is 1.
- R3: A decoded read select (`rd_sel_n_i` falling) at A2=1, A1=1 sets the arm flag.
- R4: While the flag is set, a `lds_n_i` falling edge at A2=1, A1=0 loads all 16 bits of `data_i` into `pins_out_o`.
- R5: While the flag is clear, a port write leaves `pins_out_o` unchanged.
- R6: With `BLOCK_MODE`=0, a port write clears the flag after the data is captured, so a second write without a new arm read is ignored.
- R7: While `rd_sel_n_i` is low at A2=0, A1=1, `data_oe_o` is 1 and `data_o` equals {8'h00, `pins_in_i`}. At all other times, including during the arm read, `data_oe_o` is 0 and `data_o` is 0.
- R8: With `BLOCK_MODE`=1, port writes keep the flag set, and a `lds_n_i` access at A2=0, A1=0 clears it. With `BLOCK_MODE`=0 that spare-slot access has no effect.
- R9: The arm flag is set only by the read select. A lower-strobe-only access to the arm word leaves it clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | 15 | Address lines A15..A1 (bit 0 is A1) |
| rd_sel_n_i | input | 1 | Read-only select strobe, active low |
| lds_n_i | input | 1 | Lower data strobe, active low |
| data_i | input | 16 | Data bus as seen by the port |
| data_o | output | 16 | Data driven toward the bus during an input read |
| data_oe_o | output | 1 | Bus drive enable (0 means released) |
| pins_in_i | input | 8 | Input lines |
| pins_out_o | output | 16 | Latched output lines |

## Verification
The bench runs a default-mode instance and a block-mode instance side by side on one bus. It targets the following corner cases:
- **Unarmed write.** A write with no arm read must not load; a design that fails here leaks any lower-strobe traffic to the pins.
- **Second write without re-arming.** This exposes a flag that never self-clears.
- **Spare-slot disarm.** This exposes a block mode that ignores the spare slot, or a default mode that wrongly reacts to it.
- **Arm touched by the lower strobe alone.** This exposes a design that qualifies arming with the wrong strobe.
- **Single-bit sweep of A15..A3.** Each bit is cleared in turn on both arm and write addresses, which catches an incomplete high-address compare.
- **Full sweep of the 256 input values.** This catches a mis-wired or leaking input path, and also checks that the bus stays released during the arm read.

// File: rtl/armport_pkg.sv
package armport_pkg;

    typedef enum logic [1:0] {
        SLOT_SPARE = 2'd0,
        SLOT_INPUT = 2'd1,
        SLOT_WRITE = 2'd2,
        SLOT_ARM   = 2'd3
    } slot_e;

    typedef enum logic {
        ST_DISARMED = 1'b0,
        ST_ARMED    = 1'b1
    } arm_state_e;

endpackage

// File: rtl/armport_strobe_sync.sv
module armport_strobe_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_n,
    output logic active,
    output logic assert_pulse
);
    logic [STAGES-1:0] chain;
    logic              was_active;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain      <= '1;
            was_active <= 1'b0;
        end else begin
            chain      <= {chain[STAGES-2:0], strobe_n};
            was_active <= ~chain[STAGES-1];
        end
    end

    assign active       = ~chain[STAGES-1];
    assign assert_pulse = active & ~was_active;
endmodule

// File: rtl/armport_decode.sv
module armport_decode
    import armport_pkg::*;
#(
    parameter int ADDR_W = 15
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              page_hit,
    output slot_e             slot
);
    assign page_hit = &addr[ADDR_W-1:2];
    assign slot     = slot_e'(addr[1:0]);
endmodule

// File: rtl/armport_fsm.sv
module armport_fsm
    import armport_pkg::*;
#(
    parameter bit BLOCK_MODE = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       arm_hit,
    input  logic       wr_hit,
    input  logic       disarm_hit,
    output arm_state_e state,
    output logic       load_en
);
    arm_state_e state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_DISARMED;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_DISARMED: begin
                if (arm_hit) state_nx = ST_ARMED;
            end
            ST_ARMED: begin
                if (arm_hit)                         state_nx = ST_ARMED;
                else if (!BLOCK_MODE && wr_hit)      state_nx = ST_DISARMED;
                else if (BLOCK_MODE && disarm_hit)   state_nx = ST_DISARMED;
            end
            default: state_nx = ST_DISARMED;
        endcase
    end

    always_comb begin
        load_en = 1'b0;
        unique case (state)
            ST_DISARMED: load_en = 1'b0;
            ST_ARMED:    load_en = wr_hit;
            default:     load_en = 1'b0;
        endcase
    end
endmodule

// File: rtl/armed_out_port.sv
module armed_out_port
    import armport_pkg::*;
#(
    parameter int ADDR_W      = 15,
    parameter int DATA_W      = 16,
    parameter int IN_W        = 8,
    parameter int SYNC_STAGES = 2,
    parameter bit BLOCK_MODE  = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              rd_sel_n_i,
    input  logic              lds_n_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [DATA_W-1:0] data_o,
    output logic              data_oe_o,
    input  logic [IN_W-1:0]   pins_in_i,
    output logic [DATA_W-1:0] pins_out_o
);
    localparam int PAD_W = DATA_W - IN_W;

    logic       rd_active, rd_pulse;
    logic       lds_active, lds_pulse;
    logic       page_hit;
    slot_e      slot;
    logic       arm_hit, wr_hit, disarm_hit, load_en;
    arm_state_e fsm_state;

    armport_strobe_sync #(.STAGES(SYNC_STAGES)) u_rd_sync (
        .clk(clk), .rst_n(rst_n), .strobe_n(rd_sel_n_i),
        .active(rd_active), .assert_pulse(rd_pulse)
    );

    armport_strobe_sync #(.STAGES(SYNC_STAGES)) u_lds_sync (
        .clk(clk), .rst_n(rst_n), .strobe_n(lds_n_i),
        .active(lds_active), .assert_pulse(lds_pulse)
    );

    armport_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr(addr_i), .page_hit(page_hit), .slot(slot)
    );

    // arm uses the read-only select; write and disarm use the lower strobe
    assign arm_hit    = rd_pulse  && page_hit && (slot == SLOT_ARM);
    assign wr_hit     = lds_pulse && page_hit && (slot == SLOT_WRITE);
    assign disarm_hit = lds_pulse && page_hit && (slot == SLOT_SPARE);

    armport_fsm #(.BLOCK_MODE(BLOCK_MODE)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .arm_hit(arm_hit), .wr_hit(wr_hit), .disarm_hit(disarm_hit),
        .state(fsm_state), .load_en(load_en)
    );

    // output register captures on the same edge the flag is cleared,
    // so the capture always sees the flag still set
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       pins_out_o <= '0;
        else if (load_en) pins_out_o <= data_i;
    end

    assign data_oe_o = rd_active && page_hit && (slot == SLOT_INPUT);
    assign data_o    = data_oe_o ? {{PAD_W{1'b0}}, pins_in_i} : '0;

    logic unused_lds_level;
    assign unused_lds_level = lds_active;
endmodule

// File: rtl/armed_out_port_chk.sv
module armed_out_port_chk
    import armport_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int IN_W       = 8,
    parameter bit BLOCK_MODE = 1'b0
) (
    input logic              clk,
    input logic              rst_n,
    input arm_state_e        state,
    input logic              arm_hit,
    input logic              wr_hit,
    input logic [DATA_W-1:0] data_i,
    input logic [DATA_W-1:0] data_o,
    input logic              data_oe_o,
    input logic [IN_W-1:0]   pins_in_i,
    input logic [DATA_W-1:0] pins_out_o
);
    p_arm_sets_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        arm_hit |=> state == ST_ARMED);

    p_armed_write_loads_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && state == ST_ARMED) |=> pins_out_o == $past(data_i));

    p_out_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_hit && state == ST_ARMED) |=> $stable(pins_out_o));

    p_write_consumes_arm_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!BLOCK_MODE && wr_hit) |=> state == ST_DISARMED);

    p_block_keeps_arm_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (BLOCK_MODE && wr_hit && state == ST_ARMED) |=> state == ST_ARMED);

    p_input_value_r7: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe_o |-> data_o == {{(DATA_W-IN_W){1'b0}}, pins_in_i});

    p_released_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !data_oe_o |-> data_o == '0);

    p_arm_no_drive_r7: assert property (@(posedge clk) disable iff (!rst_n)
        arm_hit |-> !data_oe_o);
endmodule

bind armed_out_port armed_out_port_chk #(
    .DATA_W(DATA_W), .IN_W(IN_W), .BLOCK_MODE(BLOCK_MODE)
) chk_i (
    .clk(clk), .rst_n(rst_n), .state(fsm_state), .arm_hit(arm_hit),
    .wr_hit(wr_hit), .data_i(data_i), .data_o(data_o), .data_oe_o(data_oe_o),
    .pins_in_i(pins_in_i), .pins_out_o(pins_out_o)
);

// File: tb/armed_out_port_tb_top.sv
module armed_out_port_tb_top;
    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic        rst_n;
    logic [14:0] addr;
    logic        rd_n, lds_n;
    logic [15:0] dbus;
    logic [7:0]  pins;
    logic [15:0] do_d, do_b, out_d, out_b;
    logic        oe_d, oe_b;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [15:0] m_out_d, m_out_b;
    bit          m_arm_d, m_arm_b;

    localparam logic [14:0] A_ARM = 15'h7FFF;
    localparam logic [14:0] A_WR  = 15'h7FFE;
    localparam logic [14:0] A_IN  = 15'h7FFD;
    localparam logic [14:0] A_SP  = 15'h7FFC;

    armed_out_port #(.BLOCK_MODE(1'b0)) dut_i (
        .clk(clk), .rst_n(rst_n), .addr_i(addr), .rd_sel_n_i(rd_n), .lds_n_i(lds_n),
        .data_i(dbus), .data_o(do_d), .data_oe_o(oe_d), .pins_in_i(pins), .pins_out_o(out_d)
    );

    armed_out_port #(.BLOCK_MODE(1'b1)) dut_blk_i (
        .clk(clk), .rst_n(rst_n), .addr_i(addr), .rd_sel_n_i(rd_n), .lds_n_i(lds_n),
        .data_i(dbus), .data_o(do_b), .data_oe_o(oe_b), .pins_in_i(pins), .pins_out_o(out_b)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    // one bus access; strobes held 6 cycles, then 4 idle cycles
    task automatic access(input logic [14:0] a, input bit rd, input bit ld,
                          input logic [15:0] d, input string tag);
        bit         pg  = &a[14:2];
        logic [1:0] s   = a[1:0];
        bit         inr = rd && pg && (s == 2'b01);
        @(negedge clk);
        addr = a; dbus = d; rd_n = !rd; lds_n = !ld;
        repeat (5) @(negedge clk);
        chk({tag, " oe dflt"}, {15'd0, oe_d}, {15'd0, inr});
        chk({tag, " oe blk"},  {15'd0, oe_b}, {15'd0, inr});
        chk({tag, " rdata dflt"}, do_d, inr ? {8'h00, pins} : 16'h0000);
        chk({tag, " rdata blk"},  do_b, inr ? {8'h00, pins} : 16'h0000);
        @(negedge clk);
        rd_n = 1'b1; lds_n = 1'b1;
        repeat (4) @(negedge clk);
        if (rd && pg && s == 2'b11) begin m_arm_d = 1'b1; m_arm_b = 1'b1; end
        if (ld && pg && s == 2'b10) begin
            if (m_arm_d) begin m_out_d = d; m_arm_d = 1'b0; end
            if (m_arm_b) m_out_b = d;
        end
        if (ld && pg && s == 2'b00) m_arm_b = 1'b0;
        chk({tag, " out dflt"}, out_d, m_out_d);
        chk({tag, " out blk"},  out_b, m_out_b);
        chk({tag, " idle oe"}, {14'd0, oe_b, oe_d}, 16'h0000);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; addr = '0; rd_n = 1'b1; lds_n = 1'b1; dbus = '0; pins = '0;
        m_out_d = '0; m_out_b = '0; m_arm_d = 1'b0; m_arm_b = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        chk("R1 reset out dflt", out_d, 16'h0000);
        chk("R1 reset out blk", out_b, 16'h0000);
        chk("R1 reset oe", {14'd0, oe_b, oe_d}, 16'h0000);

        access(A_WR, 1'b0, 1'b1, 16'hA5A5, "R1 R5 write before any arm");

        access(A_ARM, 1'b1, 1'b1, 16'h0000, "R3 arm read");
        access(A_WR, 1'b0, 1'b1, 16'h1234, "R4 armed write");
        access(A_WR, 1'b0, 1'b1, 16'h5678, "R6 R8 second write no rearm");

        for (int i = 0; i < 16; i++) begin
            access(A_ARM, 1'b1, 1'b1, 16'h0000, "R3 arm in pattern sweep");
            access(A_WR, 1'b0, 1'b1, (16'h0001 << i) ^ 16'h8C31, "R4 pattern write");
        end

        access(A_SP, 1'b0, 1'b1, 16'h0000, "R8 spare slot disarm");
        access(A_ARM, 1'b0, 1'b1, 16'h0000, "R9 arm word with lower strobe only");
        access(A_WR, 1'b0, 1'b1, 16'hBEEF, "R9 write after unqualified arm");

        access(A_ARM, 1'b1, 1'b1, 16'h0000, "R8 arm for block");
        access(A_WR, 1'b0, 1'b1, 16'h1111, "R8 block first write");
        access(A_WR, 1'b0, 1'b1, 16'h2222, "R6 R8 block second write");
        access(A_SP, 1'b0, 1'b1, 16'h0000, "R8 disarm in block");
        access(A_WR, 1'b0, 1'b1, 16'h3333, "R8 write after disarm");
        access(A_ARM, 1'b1, 1'b1, 16'h0000, "R8 rearm");
        access(A_SP, 1'b0, 1'b1, 16'h0000, "R8 spare slot in default mode");
        access(A_WR, 1'b0, 1'b1, 16'h4444, "R8 write after spare access");

        for (int b = 2; b < 15; b++) begin
            access(A_ARM & ~(15'h1 << b), 1'b1, 1'b1, 16'h0000, "R2 arm with high bit low");
            access(A_WR, 1'b0, 1'b1, 16'h6000 | 16'(b), "R2 write after bad arm");
            access(A_ARM, 1'b1, 1'b1, 16'h0000, "R2 good arm");
            access(A_WR & ~(15'h1 << b), 1'b0, 1'b1, 16'h7000 | 16'(b), "R2 write with high bit low");
            access(A_WR, 1'b0, 1'b1, 16'h9000 | 16'(b), "R2 good write");
            access(A_SP, 1'b0, 1'b1, 16'h0000, "R2 block disarm");
        end

        for (int v = 0; v < 256; v++) begin
            pins = 8'(v);
            access(A_IN, 1'b1, 1'b1, 16'h0000, "R7 input read");
        end
        pins = 8'h5A;
        access(A_ARM, 1'b1, 1'b1, 16'h0000, "R7 arm read keeps bus released");
        access(A_WR, 1'b0, 1'b1, 16'hC0DE, "R7 R4 write keeps bus released");

        done = 1'b1;
        summary();
        $finish;
    end
endmodule